// File: doc/BRIEF.md
# Step Attenuator Control Logic

This block is the digital front end of a six-bit RF step attenuator. It drives a six-bit attenuation word, 0.5 dB per LSB, to the switch array. The bit weights are 16, 8, 4, 2, 1 and 0.5 dB from MSB to LSB. The word of all zeros selects the reference (minimum) loss, and the word of all ones selects 31.5 dB.

The word can come from either of two programming paths, and a mode pin chooses between them.
- **Serial path:** a three-wire input (data, clock and a latch strobe) feeds a shift register. A transparent latch stands between that register and the output.
- **Parallel path:** six lines carry the word directly. With the strobe held high the output follows the lines. With the strobe low the output takes a new value only when the strobe is pulsed.

All control pins are asynchronous. A fast system clock oversamples them through a two-flop synchronizer. Serial clock edges are found by comparing successive samples.

When synchronous reset is released, the block sets a known initial state before any programming arrives:
- In serial mode, or in parallel mode with the strobe high, the initial word is taken from the parallel lines.
- In parallel mode with the strobe low, two preset-select pins choose one of four fixed words.

Top module: `step_atten_ctrl`

## Requirements
- R1: While `rst` is high, and until the startup load, `atten_o` is 6'b000000.
- R2: In serial mode (`ser_mode_i`=1), the first bit shifted in on a rising `sclk_i` ends up in bit 5 (16 dB), and the sixth bit ends up in bit 0 (0.5 dB). A strobe pulse then moves the word to `atten_o`.
- R3: Bits shift in on every rising `sclk_i` whether `strobe_i` is high or low. While `strobe_i` is low during loading, `atten_o` does not change.
- R4: In serial mode with `strobe_i` high, `atten_o` follows the shift register after every shift, including after a partial word.
- R5: In either mode, while `strobe_i` is low after startup, `atten_o` holds its value.
- R6: In parallel mode (`ser_mode_i`=0) with `strobe_i` high, `atten_o` follows `par_word_i`.
- R7: In parallel mode with `strobe_i` low, a change on `par_word_i` is ignored until `strobe_i` is pulsed high and returned low. After the pulse, `atten_o` holds the new word.
- R8: At startup in serial mode, or in parallel mode with `strobe_i` high, `atten_o` is loaded from `par_word_i`.
- R9: At startup in parallel mode with `strobe_i` low, `par_word_i` is ignored and `preset_i` ({MSB,LSB}) selects the word: 00 gives 6'b000000, 01 gives 6'b010000 (8 dB), 10 gives 6'b100000 (16 dB), and 11 gives 6'b111110 (31 dB).
- R10: After the startup load, `preset_i` has no effect until the next reset.
- R11: A change on `par_word_i` in transparent parallel mode appears on `atten_o` after the third rising `clk` edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the control pins |
| rst | input | 1 | Synchronous active-high reset; its release starts the startup load |
| ser_mode_i | input | 1 | Path select: 1 for serial, 0 for parallel |
| strobe_i | input | 1 | Latch strobe shared by both paths |
| sdata_i | input | 1 | Serial data, MSB first |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| par_word_i | input | 6 | Parallel attenuation word |
| preset_i | input | 2 | Startup preset select, bit 1 is the MSB |
| atten_o | output | 6 | Registered attenuation word to the switch array |

## Verification
A corrupted shift register shows up in two ways:
- With the strobe high, it appears on `atten_o` four clock cycles after the offending serial clock edge.
- With the strobe low, it stays hidden until the next strobe pulse, so the bench loads words with the strobe low and checks the held value both before and after the pulse.

A wrong startup decision is visible within three clock cycles of reset release and then persists, because nothing reloads the preset. The bench therefore checks every preset code, and toggles the preset pins after startup.

A wrong latch state in parallel mode shows up as `atten_o` tracking `par_word_i` while the strobe is low.

// File: rtl/atten_pkg.sv
package atten_pkg;
  localparam int WORD_W      = 6;
  localparam int SYNC_STAGES = 2;
  localparam int PRESET_W    = 2;

  // Startup preset decode; sel = {msb, lsb}
  function automatic logic [WORD_W-1:0] preset_word(input logic [PRESET_W-1:0] sel);
    logic [WORD_W-1:0] w;
    case (sel)
      2'b00:   w = '0;
      2'b01:   w = WORD_W'(1) << (WORD_W-2);
      2'b10:   w = WORD_W'(1) << (WORD_W-1);
      default: w = {{(WORD_W-1){1'b1}}, 1'b0};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/atten_sync.sv
module atten_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/atten_shifter.sv
module atten_shifter #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic [WORD_W-1:0] word_o
);
  logic sclk_d;
  logic rise;

  assign rise = sclk_s & ~sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      word_o <= '0;
    end else begin
      sclk_d <= sclk_s;
      if (rise) word_o <= {word_o[WORD_W-2:0], sdata_s};
    end
  end
endmodule

// File: rtl/atten_output.sv
module atten_output
  import atten_pkg::*;
#(
  parameter int W      = WORD_W,
  parameter int WAIT_N = SYNC_STAGES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_s,
  input  logic                le_s,
  input  logic [W-1:0]        par_s,
  input  logic [PRESET_W-1:0] pre_s,
  input  logic [W-1:0]        shreg,
  output logic                init_done,
  output logic [W-1:0]        atten_o
);
  localparam int CNT_W = $clog2(WAIT_N + 1);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     src;

  assign src = mode_s ? shreg : par_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      init_done <= 1'b0;
      atten_o   <= '0;
    end else if (!init_done) begin
      if (cnt == CNT_W'(WAIT_N)) begin
        init_done <= 1'b1;
        if (!mode_s && !le_s) atten_o <= preset_word(pre_s);
        else                  atten_o <= par_s;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (le_s) begin
      atten_o <= src;
    end
  end
endmodule

// File: rtl/step_atten_ctrl.sv
module step_atten_ctrl
  import atten_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                ser_mode_i,
  input  logic                strobe_i,
  input  logic                sdata_i,
  input  logic                sclk_i,
  input  logic [WORD_W-1:0]   par_word_i,
  input  logic [PRESET_W-1:0] preset_i,
  output logic [WORD_W-1:0]   atten_o
);
  localparam int PIN_W = WORD_W + PRESET_W + 4;

  logic [PIN_W-1:0]    pins_s;
  logic                mode_s, le_s, sdata_s, sclk_s;
  logic [WORD_W-1:0]   par_s, shreg;
  logic [PRESET_W-1:0] pre_s;
  logic                init_done;

  atten_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ser_mode_i, strobe_i, sdata_i, sclk_i, par_word_i, preset_i}),
    .q_o (pins_s)
  );

  assign {mode_s, le_s, sdata_s, sclk_s, par_s, pre_s} = pins_s;

  atten_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (sclk_s),
    .sdata_s (sdata_s),
    .word_o  (shreg)
  );

  atten_output #(.W(WORD_W), .WAIT_N(SYNC_STAGES)) u_out (
    .clk       (clk),
    .rst       (rst),
    .mode_s    (mode_s),
    .le_s      (le_s),
    .par_s     (par_s),
    .pre_s     (pre_s),
    .shreg     (shreg),
    .init_done (init_done),
    .atten_o   (atten_o)
  );
endmodule

// File: rtl/step_atten_ctrl_chk.sv
module step_atten_ctrl_chk
  import atten_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mode_s,
  input logic              le_s,
  input logic [WORD_W-1:0] par_s,
  input logic [WORD_W-1:0] shreg,
  input logic              init_done,
  input logic [WORD_W-1:0] atten_o
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> atten_o == '0);

  p_ser_follow_r4: assert property (@(posedge clk) disable iff (rst)
    (init_done && le_s && mode_s) |=> atten_o == $past(shreg));

  p_hold_low_r5: assert property (@(posedge clk) disable iff (rst)
    (init_done && !le_s) |=> $stable(atten_o));

  p_par_follow_r6: assert property (@(posedge clk) disable iff (rst)
    (init_done && le_s && !mode_s) |=> atten_o == $past(par_s));

  p_init_once_r10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
endmodule

bind step_atten_ctrl step_atten_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_s    (mode_s),
  .le_s      (le_s),
  .par_s     (par_s),
  .shreg     (shreg),
  .init_done (init_done),
  .atten_o   (atten_o)
);

// File: tb/tb_step_atten_ctrl.sv
`timescale 1ns/1ps
module tb_step_atten_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_mode_i = 1'b0, strobe_i = 1'b0, sdata_i = 1'b0, sclk_i = 1'b0;
  logic [5:0] par_word_i = '0;
  logic [1:0] preset_i = '0;
  logic [5:0] atten_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  step_atten_ctrl dut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [5:0] exp);
    checks++;
    if (atten_o !== exp) begin
      errors++;
      $display("FAIL %s: atten_o=%h expected=%h", req, atten_o, exp);
    end
  endtask

  task automatic boot(input logic m, input logic le, input logic [5:0] p, input logic [1:0] pr);
    @(negedge clk);
    rst = 1'b1; ser_mode_i = m; strobe_i = le; par_word_i = p; preset_i = pr; sclk_i = 0;
    cyc(3);
    rst = 1'b0;
    cyc(8);
  endtask

  task automatic shift_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) begin
      sdata_i = w[i]; cyc(3);
      sclk_i = 1'b1;  cyc(3);
      sclk_i = 1'b0;  cyc(3);
    end
  endtask

  task automatic pulse_le();
    strobe_i = 1'b1; cyc(4);
    strobe_i = 1'b0; cyc(6);
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; par_word_i = 6'h3F; cyc(3);
    chk("R1 reset", 6'h00);
    rst = 1'b0; cyc(1);
    chk("R1 before load", 6'h00);
    cyc(6);
  endtask

  task automatic t_powerup_load();
    boot(1'b1, 1'b0, 6'h2B, 2'b11); chk("R8 serial startup", 6'h2B);
    boot(1'b0, 1'b1, 6'h15, 2'b10); chk("R8 parallel LE high startup", 6'h15);
  endtask

  task automatic t_presets();
    boot(1'b0, 1'b0, 6'h3F, 2'b00); chk("R9 preset 00", 6'h00);
    boot(1'b0, 1'b0, 6'h3F, 2'b01); chk("R9 preset 01", 6'h10);
    boot(1'b0, 1'b0, 6'h3F, 2'b10); chk("R9 preset 10", 6'h20);
    boot(1'b0, 1'b0, 6'h3F, 2'b11); chk("R9 preset 11", 6'h3E);
    preset_i = 2'b00; cyc(10);
    chk("R10 preset pins ignored after startup", 6'h3E);
  endtask

  task automatic t_serial_latched();
    boot(1'b1, 1'b0, 6'h00, 2'b00);
    shift_word(6'b101101);
    chk("R3 load with LE low holds output", 6'h00);
    pulse_le();
    chk("R2 MSB-first word latched", 6'h2D);
    shift_word(6'h13);
    chk("R5 serial hold while LE low", 6'h2D);
    pulse_le();
    chk("R2 second word latched", 6'h13);
  endtask

  task automatic t_serial_transparent();
    strobe_i = 1'b1; cyc(6);
    chk("R4 transparent shows register", 6'h13);
    sdata_i = 1'b1; cyc(3); sclk_i = 1'b1; cyc(3); sclk_i = 1'b0; cyc(4);
    chk("R4 follows partial shift", 6'h27);
    strobe_i = 1'b0; cyc(6);
  endtask

  task automatic t_parallel();
    ser_mode_i = 1'b0; strobe_i = 1'b1; par_word_i = 6'h2A; cyc(6);
    chk("R6 direct follow", 6'h2A);
    par_word_i = 6'h01; cyc(6);
    chk("R6 direct follow 2", 6'h01);
    strobe_i = 1'b0; cyc(6);
    par_word_i = 6'h3C; cyc(8);
    chk("R7 ignored while LE low", 6'h01);
    pulse_le();
    chk("R7 latched after pulse", 6'h3C);
    par_word_i = 6'h05; cyc(8);
    chk("R5 parallel hold after pulse", 6'h3C);
  endtask

  task automatic t_latency();
    strobe_i = 1'b1; cyc(6);
    chk("R11 setup", 6'h05);
    par_word_i = 6'h22;
    cyc(2);
    chk("R11 not after two edges", 6'h05);
    cyc(1);
    chk("R11 after three edges", 6'h22);
    strobe_i = 1'b0; cyc(6);
  endtask

  initial begin
    t_reset();
    t_powerup_load();
    t_presets();
    t_serial_latched();
    t_serial_transparent();
    t_parallel();
    t_latency();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule